// File: doc/BRIEF.md
# Quasi-Resonant Gate Timing Controller

This block sets the switching instants of a flyback power switch. It works only on digital flags: two demagnetisation comparators, a primary current-sense comparator, and a 4-bit code for the error-amplifier level. The gate turns on at the first demagnetisation valley that follows a load-dependent blanking window, after a short settling delay. It turns off when the current-sense comparator trips after a leading-edge blanking interval. A starter timer, with a slow and a fast rate chosen by the load code, fires the gate when no usable valley arrives.

All intervals are counted in clock cycles from the most recent gate turn-on. A low load code lengthens the blanking window, so the controller skips valleys and lowers its switching frequency. Burst and fault logic upstream drive the enable input, which parks the gate low and clears the controller's history.

Top module: `qr_gate_ctrl`

## Requirements
- R1: While `rst_n` or `en` is low, `gate` is low from the next clock edge. A low `en` also clears the arm flag and the turn-on timer. After `en` rises again, a turn-on needs a fresh arming edge, and the starter waits its full period counted from the enable.
- R2: A falling edge of `zcd_hi` (1 in one cycle, 0 in the next) turns the gate on only if `zcd_arm` has had a rising edge (0 then 1) since the last turn-on and before that fall. A fall with no earlier arming edge does nothing.
- R3: A valid fall moves the controller into a settling state. `gate` rises `TRIG_DELAY_CYC` clock edges after the edge that samples the fall.
- R4: A fall sampled while the turn-on timer is below the blanking length is ignored and leaves the arm flag set. The first armed fall at or after the blanking length fires. Falls sampled during the settling state are ignored.
- R5: The blanking length for code c (0 = lowest load level, 2^COMP_W-1 = highest) is `BLANK_MAX_CYC - (BLANK_MAX_CYC-BLANK_MIN_CYC)*c/(2^COMP_W-1)`, using integer division, and never less than `MIN_PERIOD_CYC`. It is compared with the number of edges since the gate last rose.
- R6: When the gate is off and not settling, and the turn-on timer reaches the starter period, the gate rises at the next edge. The period is `STARTER_FAST_CYC` when `comp_code >= BURST_CODE` and `STARTER_SLOW_CYC` otherwise.
- R7: `cs_trip` is ignored for the first `LEB_CYC` edges after the gate rises. When it is sampled high after that window, the gate falls at that edge.
- R8: Every turn-on clears the arm flag, so each switching cycle needs a new arming edge.
- R9: Falls of `zcd_hi` sampled while the gate is high are ignored.
- R10: A valid fall and starter expiry can be sampled in the same cycle. The valid fall takes precedence, and the gate rises after the settling delay, not at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run permission from burst/fault logic |
| comp_code | input | COMP_W | Quantised error-amplifier level, 0 = lowest |
| zcd_arm | input | 1 | High while the demagnetisation pin is above the arming level |
| zcd_hi | input | 1 | High while the demagnetisation pin is above the trigger level |
| cs_trip | input | 1 | High while the sensed current exceeds the peak limit |
| gate | output | 1 | Power switch gate command |

## Verification
Two functions can fall in the same cycle: a valid armed valley edge and the starter expiry. The bench provokes this by arming early and then dropping `zcd_hi` exactly in the cycle where the turn-on timer equals the fast starter period. The result is judged by the rise time. A rise one edge later would mean the starter won. The expected rise comes `TRIG_DELAY_CYC` edges after the sampled fall, because the valley path has precedence. The bench also places falls one cycle either side of each blanking boundary, so that a window that is off by one shows up as a different rise time.

// File: rtl/qr_ctrl_pkg.sv
package qr_ctrl_pkg;

    // Switching phase of the gate controller
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,   // gate low, waiting for valley or starter
        PH_SETTLE  = 2'd1,   // valid valley seen, waiting the settling delay
        PH_CONDUCT = 2'd2    // gate high, waiting for current-sense trip
    } phase_e;

    // Demagnetisation edge tracker state
    typedef struct packed {
        logic armed;
        logic arm_prev;
        logic hi_prev;
    } zcd_st_t;

endpackage

// File: rtl/qr_blank_lut.sv
module qr_blank_lut #(
    parameter int COMP_W        = 4,
    parameter int CNT_W         = 17,
    parameter int BLANK_MAX_CYC = 6000,
    parameter int BLANK_MIN_CYC = 1200,
    parameter int FLOOR_CYC     = 1205
) (
    input  logic [COMP_W-1:0] code,
    output logic [CNT_W-1:0]  blank_cyc
);
    localparam int ENTRIES = 2 ** COMP_W;
    localparam int SPAN    = BLANK_MAX_CYC - BLANK_MIN_CYC;
    localparam int STEPS   = ENTRIES - 1;

    logic [CNT_W-1:0] tbl [ENTRIES];

    // One constant per code, linear from the longest to the shortest window
    for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
        localparam int RAW = BLANK_MAX_CYC - (SPAN * i) / STEPS;
        localparam int VAL = (RAW < FLOOR_CYC) ? FLOOR_CYC : RAW;
        assign tbl[i] = CNT_W'(VAL);
    end

    assign blank_cyc = tbl[code];

endmodule

// File: rtl/qr_zcd_track.sv
module qr_zcd_track
    import qr_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic arm_in,
    input  logic hi_in,
    input  logic consume,   // gate turn-on this cycle: drop the arm flag
    output logic armed,
    output logic fall
);
    zcd_st_t st_d, st_q;
    logic    arm_rise;

    always_comb begin
        st_d          = st_q;
        arm_rise      = arm_in & ~st_q.arm_prev;
        st_d.arm_prev = arm_in;
        st_d.hi_prev  = hi_in;
        if (!en || consume) begin
            st_d.armed = 1'b0;          // clearing wins over a coincident arming edge
        end else if (arm_rise) begin
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign armed = st_q.armed;
    assign fall  = st_q.hi_prev & ~hi_in;

endmodule

// File: rtl/qr_starter.sv
module qr_starter #(
    parameter int COMP_W           = 4,
    parameter int CNT_W            = 17,
    parameter int STARTER_SLOW_CYC = 100000,
    parameter int STARTER_FAST_CYC = 25000,
    parameter int BURST_CODE       = 4
) (
    input  logic [COMP_W-1:0] code,
    input  logic [CNT_W-1:0]  tmr,
    output logic              expire
);
    localparam logic [CNT_W-1:0]  SLOW_LIM = CNT_W'(STARTER_SLOW_CYC);
    localparam logic [CNT_W-1:0]  FAST_LIM = CNT_W'(STARTER_FAST_CYC);
    localparam logic [COMP_W-1:0] BURST_C  = COMP_W'(BURST_CODE);

    logic [CNT_W-1:0] period;

    always_comb begin
        period = (code >= BURST_C) ? FAST_LIM : SLOW_LIM;
        expire = (tmr >= period);
    end

endmodule

// File: rtl/qr_gate_ctrl.sv
module qr_gate_ctrl
    import qr_ctrl_pkg::*;
#(
    parameter int COMP_W           = 4,
    parameter int BLANK_MAX_CYC    = 6000,
    parameter int BLANK_MIN_CYC    = 1200,
    parameter int MIN_PERIOD_CYC   = 1205,
    parameter int STARTER_SLOW_CYC = 100000,
    parameter int STARTER_FAST_CYC = 25000,
    parameter int BURST_CODE       = 4,
    parameter int LEB_CYC          = 50,
    parameter int TRIG_DELAY_CYC   = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [COMP_W-1:0] comp_code,
    input  logic              zcd_arm,
    input  logic              zcd_hi,
    input  logic              cs_trip,
    output logic              gate
);
    localparam int TOP_A   = (STARTER_SLOW_CYC > BLANK_MAX_CYC) ? STARTER_SLOW_CYC : BLANK_MAX_CYC;
    localparam int TOP_B   = (TOP_A > MIN_PERIOD_CYC) ? TOP_A : MIN_PERIOD_CYC;
    localparam int TOP_C   = (TOP_B > LEB_CYC) ? TOP_B : LEB_CYC;
    localparam int TMR_W   = $clog2(TOP_C + 2);
    localparam int DLY_W   = (TRIG_DELAY_CYC > 1) ? $clog2(TRIG_DELAY_CYC) : 1;
    localparam logic [TMR_W-1:0] TMR_SAT  = '1;
    localparam logic [TMR_W-1:0] LEB_LIM  = TMR_W'(LEB_CYC);
    localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(TRIG_DELAY_CYC - 1);

    typedef struct packed {
        phase_e           phase;
        logic [TMR_W-1:0] tmr;    // edges since the gate last rose
        logic [DLY_W-1:0] dly;    // settling delay count
    } ctl_st_t;

    ctl_st_t          ctl_d, ctl_q;
    logic             armed, fall, start_exp, turn_on, valley_ok;
    logic [TMR_W-1:0] blank_cyc;

    qr_blank_lut #(
        .COMP_W        (COMP_W),
        .CNT_W         (TMR_W),
        .BLANK_MAX_CYC (BLANK_MAX_CYC),
        .BLANK_MIN_CYC (BLANK_MIN_CYC),
        .FLOOR_CYC     (MIN_PERIOD_CYC)
    ) u_blank (
        .code      (comp_code),
        .blank_cyc (blank_cyc)
    );

    qr_zcd_track u_zcd (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .arm_in  (zcd_arm),
        .hi_in   (zcd_hi),
        .consume (turn_on),
        .armed   (armed),
        .fall    (fall)
    );

    qr_starter #(
        .COMP_W           (COMP_W),
        .CNT_W            (TMR_W),
        .STARTER_SLOW_CYC (STARTER_SLOW_CYC),
        .STARTER_FAST_CYC (STARTER_FAST_CYC),
        .BURST_CODE       (BURST_CODE)
    ) u_start (
        .code   (comp_code),
        .tmr    (ctl_q.tmr),
        .expire (start_exp)
    );

    always_comb begin
        ctl_d     = ctl_q;
        turn_on   = 1'b0;
        valley_ok = armed && fall && (ctl_q.tmr >= blank_cyc);
        ctl_d.tmr = (ctl_q.tmr == TMR_SAT) ? ctl_q.tmr : ctl_q.tmr + 1'b1;

        unique case (ctl_q.phase)
            PH_IDLE: begin
                if (valley_ok) begin              // valley path has precedence
                    ctl_d.phase = PH_SETTLE;
                    ctl_d.dly   = '0;
                end else if (start_exp) begin
                    ctl_d.phase = PH_CONDUCT;
                    turn_on     = 1'b1;
                end
            end
            PH_SETTLE: begin
                if (ctl_q.dly == DLY_LAST) begin
                    ctl_d.phase = PH_CONDUCT;
                    turn_on     = 1'b1;
                end else begin
                    ctl_d.dly = ctl_q.dly + 1'b1;
                end
            end
            PH_CONDUCT: begin
                if (cs_trip && (ctl_q.tmr >= LEB_LIM)) begin
                    ctl_d.phase = PH_IDLE;
                end
            end
            default: ctl_d.phase = PH_IDLE;
        endcase

        if (turn_on) begin
            ctl_d.tmr = '0;
        end

        if (!en) begin
            ctl_d   = '{phase: PH_IDLE, tmr: '0, dly: '0};
            turn_on = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{phase: PH_IDLE, tmr: '0, dly: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign gate = (ctl_q.phase == PH_CONDUCT);

endmodule

// File: rtl/qr_gate_ctrl_chk.sv
module qr_gate_ctrl_chk #(
    parameter int MIN_PERIOD_CYC   = 1205,
    parameter int STARTER_SLOW_CYC = 100000,
    parameter int LEB_CYC          = 50,
    parameter int TRIG_DELAY_CYC   = 40
) (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic gate
);
    logic [31:0] gap_q, off_q, hi_q;
    logic        gate_prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q       <= '0;
            off_q       <= '0;
            hi_q        <= '0;
            gate_prev_q <= 1'b0;
        end else begin
            gate_prev_q <= gate;
            if (!en || (gate && !gate_prev_q)) gap_q <= '0;
            else if (gap_q != '1)              gap_q <= gap_q + 1;
            if (!en || gate)                   off_q <= '0;
            else if (off_q != '1)              off_q <= off_q + 1;
            if (!gate)                         hi_q  <= '0;
            else if (hi_q != '1)               hi_q  <= hi_q + 1;
        end
    end

    assert_gate_low_when_disabled_R1: assert property (
        @(posedge clk) disable iff (!rst_n) !en |=> !gate);

    assert_rise_spacing_R5: assert property (
        @(posedge clk) disable iff (!rst_n) $rose(gate) |-> gap_q >= 32'(MIN_PERIOD_CYC));

    assert_starter_bound_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        off_q <= 32'(STARTER_SLOW_CYC + TRIG_DELAY_CYC + 2));

    assert_leb_respected_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        ($fell(gate) && $past(en)) |-> hi_q > 32'(LEB_CYC));

endmodule

bind qr_gate_ctrl qr_gate_ctrl_chk #(
    .MIN_PERIOD_CYC   (MIN_PERIOD_CYC),
    .STARTER_SLOW_CYC (STARTER_SLOW_CYC),
    .LEB_CYC          (LEB_CYC),
    .TRIG_DELAY_CYC   (TRIG_DELAY_CYC)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .gate  (gate)
);

// File: tb/qr_gate_ctrl_test.sv
module qr_gate_ctrl_test;
    localparam int BMAX = 300;
    localparam int BMIN = 60;
    localparam int MINP = 60;
    localparam int SLOW = 2000;
    localparam int FAST = 500;
    localparam int BRST = 4;
    localparam int LEB  = 10;
    localparam int DLY  = 4;

    // blank(c) = 300 - 16c ; starter fires at t = period, visible at period+1
    // valid fall at t visible as gate high at t+1+DLY
    typedef struct packed {
        int code; int arm_t; int f1; int f2; int exp_t; int req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{15, 20,  60,  -1,   65,  3},  // R3: valid fall at blank edge 60
        '{15, 20,  59,  -1,  501,  4},  // R4: one cycle early, ignored -> fast starter
        '{ 8, 20, 100, 172,  177,  4},  // R4: first fall blanked, second at 172 fires
        '{ 0, 20, 298, 300,  305,  5},  // R5: code 0 window 300
        '{ 0, -1, 400,  -1, 2001,  2},  // R2: no arming -> slow starter
        '{ 3, 20, 252,  -1,  257,  5},  // R5: code 3 window 252
        '{ 3, -1,  -1,  -1, 2001,  6},  // R6: below burst code -> slow starter
        '{ 4, -1,  -1,  -1,  501,  6},  // R6: at burst code -> fast starter
        '{15,  5,   8,  70,   75,  9},  // R9: fall while gate high ignored
        '{15, -1, 100,  -1,  501,  8},  // R8: arm consumed by previous turn-on
        '{ 4, 20, 500,  -1,  505, 10},  // R10: valid fall coincides with starter expiry
        '{15, 20,  60,  62,   65,  4},  // R4: fall during settling ignored
        '{15, 80,  70,  -1,  501,  2}   // R2: arming after the fall does not count
    };

    logic       clk = 1'b0;
    logic       rst_n, en, zcd_arm, zcd_hi, cs_trip;
    logic [3:0] comp_code;
    logic       gate;
    int         checks = 0;
    int         fails  = 0;
    bit         done   = 1'b0;

    always #2.5 clk = ~clk;

    qr_gate_ctrl #(
        .COMP_W(4), .BLANK_MAX_CYC(BMAX), .BLANK_MIN_CYC(BMIN), .MIN_PERIOD_CYC(MINP),
        .STARTER_SLOW_CYC(SLOW), .STARTER_FAST_CYC(FAST), .BURST_CODE(BRST),
        .LEB_CYC(LEB), .TRIG_DELAY_CYC(DLY)
    ) uut (
        .clk(clk), .rst_n(rst_n), .en(en), .comp_code(comp_code),
        .zcd_arm(zcd_arm), .zcd_hi(zcd_hi), .cs_trip(cs_trip), .gate(gate)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_vec(input int idx);
        vec_t v;
        int   rise;
        v    = VECS[idx];
        rise = -1;
        comp_code = v.code[3:0];
        zcd_arm   = (v.arm_t == 0);
        zcd_hi    = 1'b1;
        for (int k = 1; k <= 4000; k++) begin
            @(negedge clk);
            if (k == LEB)     check(gate == 1'b1, "R7", int'(gate), 1);
            if (k == LEB + 1) check(gate == 1'b0, "R7", int'(gate), 0);
            if (k > LEB + 1 && gate) begin
                rise = k;
                break;
            end
            zcd_arm = (k == v.arm_t);
            zcd_hi  = !(k == v.f1 || k == v.f2);
        end
        zcd_arm = 1'b0;
        zcd_hi  = 1'b1;
        check(rise == v.exp_t, $sformatf("R%0d", v.req), rise, v.exp_t);
    endtask

    initial begin
        int rise;
        bit leak;
        rst_n = 1'b0; en = 1'b1; cs_trip = 1'b1;
        zcd_arm = 1'b0; zcd_hi = 1'b1; comp_code = 4'd0;
        repeat (5) @(negedge clk);
        check(gate == 1'b0, "R1 reset", int'(gate), 0);
        rst_n = 1'b1;

        // R6: first turn-on after reset comes from the slow starter
        rise = -1;
        for (int k = 1; k <= 2100; k++) begin
            @(negedge clk);
            if (gate) begin rise = k; break; end
        end
        check(rise == SLOW + 1, "R6 startup", rise, SLOW + 1);

        for (int i = 0; i < NV; i++) run_vec(i);

        // R1: disable while gate high, arm while disabled, re-enable
        en = 1'b0;
        @(negedge clk);
        check(gate == 1'b0, "R1 disable", int'(gate), 0);
        comp_code = 4'd4;
        leak = 1'b0;
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            if (gate) leak = 1'b1;
            zcd_arm = (k == 10);
        end
        check(leak == 1'b0, "R1 held low", int'(leak), 0);
        en = 1'b1;
        rise = -1;
        for (int k = 1; k <= 1000; k++) begin
            @(negedge clk);
            if (gate) begin rise = k; break; end
            zcd_hi = !(k == 300);
        end
        zcd_hi = 1'b1;
        check(rise == FAST + 1, "R1 re-enable", rise, FAST + 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule